// File: doc/BRIEF.md
# SIMD Lane-Wise Add/Subtract Unit

This execute unit handles vector three-register instructions that work on equal-size elements. It takes a 32-bit instruction word and two 128-bit source vectors. Both vectors are cut into independent lanes of 8, 16, 32 or 64 bits. Each result lane is the sum or the difference of the two source lanes in the same position. A field in the instruction picks the lane width. A second bit picks a 64-bit or a 128-bit vector. A third bit turns the add into a subtract.

The unit also decodes the word far enough to sort it into four outcomes:
- a legal arithmetic operation, which writes the destination;
- an illegal element-size/width pairing;
- the bitwise-logic group, which is flagged for routing to a separate unit;
- any other opcode, which is flagged as unimplemented.

Only a legal arithmetic operation writes the destination. Every accepted instruction also produces the next program counter, which is the incoming value plus four.

The source register indices leave the unit combinationally, so a register file can be read in the same cycle. All other results are registered and appear one clock after the instruction is accepted. A parameter selects how the lanes are built:
- a bank of separate adders for each lane width, followed by a selector;
- a single carry chain that is cut at lane boundaries.

Top module: `simd_addsub_unit`

## Requirements
- R1: Field decode: destination index from instruction bits [4:0], first source index (rn_idx) from [9:5], second source index (rm_idx) from [20:16], opcode from [15:11], element-size code from [23:22], subtract bit from [29] and width bit from [30]; rn_idx and rm_idx follow insn combinationally in the same cycle.
- R2: The lane width is 8 << size code (00=8, 01=16, 10=32, 11=64 bits). Lane 0 occupies the least significant bits. No carry or borrow crosses a lane boundary.
- R3: With the subtract bit at 0 each lane is vn + vm. With it at 1 each lane is vn - vm. Both wrap modulo 2 to the power of the lane width.
- R4: With width bit 0 the vector is 64 bits and res_data[127:64] is zero. With width bit 1 all 128 bits carry lane results.
- R5: Opcode 10000 with size code 11 and width bit 0 raises illegal and leaves wr_en low.
- R6: Opcode 00011 raises logic_route and leaves wr_en, illegal and unimpl low. This holds for any size code or width bit, including size 11 with width 0.
- R7: Any opcode other than 10000 and 00011 raises unimpl and leaves wr_en low. For each accepted instruction exactly one of wr_en, illegal, unimpl and logic_route is high.
- R8: For every accepted instruction, whatever its outcome, pc_next equals pc_in + 4.
- R9: Outputs are registered. The results of an instruction accepted at a clock edge are visible after that edge. When in_valid is low at an edge, out_valid and wr_en are low after it. Back-to-back instructions are each handled.
- R10: While reset is asserted, out_valid, wr_en, illegal, unimpl, logic_route, res_data and pc_next are zero.
- R11: Both lane construction styles (ADDER_STYLE 0 banked, 1 segmented) give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| insn | input | INSN_W (32) | Instruction word |
| pc_in | input | PC_W (64) | Program counter of the instruction |
| vn_data | input | VEC_W (128) | First source vector value |
| vm_data | input | VEC_W (128) | Second source vector value |
| rn_idx | output | 5 | First source register index (combinational) |
| rm_idx | output | 5 | Second source register index (combinational) |
| out_valid | output | 1 | Registered results are for an accepted instruction |
| res_data | output | VEC_W (128) | Lane-wise result |
| rd_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Write res_data to destination rd_idx |
| illegal | output | 1 | Illegal element-size/width combination |
| unimpl | output | 1 | Opcode not handled here or by the logic unit |
| logic_route | output | 1 | Bitwise-logic opcode, to be handled by the logic unit |
| pc_next | output | PC_W (64) | pc_in + 4 of the accepted instruction |

## Verification
Two functions can meet in one cycle: isolating the lanes and zeroing the upper half on a 64-bit vector. Lanes whose top lane overflows at bit 63 are run with the width bit at 0, for example eight 8-bit lanes of 0x80 + 0x80 and 32-bit lanes of 0xFFFFFFFF + 1. The bench then confirms that every lane wrapped to its own value and that bits [127:64] stayed zero, rather than receiving the carry or the full 128-bit sum. A second pairing puts an illegal encoding in the same cycle as the program-counter step: illegal must rise with wr_en low while pc_next still shows the +4 advance.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

   // Instruction field positions (fixed by the encoding)
   localparam int FLD_RD_LO  = 0;
   localparam int FLD_RN_LO  = 5;
   localparam int FLD_OPC_LO = 11;
   localparam int FLD_RM_LO  = 16;
   localparam int FLD_SZ_LO  = 22;
   localparam int FLD_U      = 29;
   localparam int FLD_Q      = 30;

   localparam int REG_IDX_W  = 5;
   localparam int OPC_W      = 5;
   localparam int SZ_W       = 2;
   localparam int NUM_SIZES  = 1 << SZ_W;

   localparam logic [OPC_W-1:0] OPC_ARITH = 5'b10000;
   localparam logic [OPC_W-1:0] OPC_LOGIC = 5'b00011;

   localparam int PC_STEP = 4;

   localparam int ADD_BANKED    = 0;
   localparam int ADD_SEGMENTED = 1;

   typedef enum logic [SZ_W-1:0] {
      EW_8  = 2'b00,
      EW_16 = 2'b01,
      EW_32 = 2'b10,
      EW_64 = 2'b11
   } elem_sz_e;

   typedef struct packed {
      logic                  q;
      logic                  u;
      elem_sz_e              sz;
      logic [REG_IDX_W-1:0]  rd;
      logic [REG_IDX_W-1:0]  rn;
      logic [REG_IDX_W-1:0]  rm;
      logic                  is_arith;
      logic                  is_logic;
      logic                  is_unimpl;
      logic                  is_illegal;
      logic                  do_write;
   } dec_t;

endpackage

// File: rtl/simd_decode.sv
module simd_decode
   import simd_addsub_pkg::*;
#(
   parameter int INSN_W = 32
) (
   input  logic [INSN_W-1:0] insn,
   output dec_t              dec
);

   logic [OPC_W-1:0] opc;
   logic             unused_bits;

   assign opc         = insn[FLD_OPC_LO +: OPC_W];
   assign unused_bits = ^{insn[INSN_W-1], insn[28:24], insn[21], insn[10]};

   always_comb begin
      dec.q          = insn[FLD_Q];
      dec.u          = insn[FLD_U];
      dec.sz         = elem_sz_e'(insn[FLD_SZ_LO +: SZ_W]);
      dec.rd         = insn[FLD_RD_LO +: REG_IDX_W];
      dec.rn         = insn[FLD_RN_LO +: REG_IDX_W];
      dec.rm         = insn[FLD_RM_LO +: REG_IDX_W];
      dec.is_arith   = (opc == OPC_ARITH);
      dec.is_logic   = (opc == OPC_LOGIC);
      dec.is_unimpl  = !dec.is_arith && !dec.is_logic;
      // 64-bit lanes need a 128-bit vector; only the arithmetic path checks it
      dec.is_illegal = dec.is_arith && (dec.sz == EW_64) && !dec.q;
      dec.do_write   = dec.is_arith && !dec.is_illegal;
   end

endmodule

// File: rtl/simd_lane.sv
module simd_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);

   logic [W-1:0] b_eff;

   generate
      if (W < 1) begin : g_bad_w
         $error("simd_lane: W must be at least 1");
      end
   endgenerate

   // Single adder: subtract is a + ~b + 1, the result wraps at W bits
   assign b_eff = b ^ {W{sub}};
   assign y     = a + b_eff + W'(sub);

endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
   import simd_addsub_pkg::*;
#(
   parameter int VEC_W       = 128,
   parameter int LANE_MIN    = 8,
   parameter int ADDER_STYLE = ADD_BANKED
) (
   input  logic [VEC_W-1:0] a,
   input  logic [VEC_W-1:0] b,
   input  logic             sub,
   input  logic [SZ_W-1:0]  sz,
   output logic [VEC_W-1:0] y
);

   localparam int LANE_MAX = LANE_MIN << (NUM_SIZES - 1);
   localparam int NCHUNK   = VEC_W / LANE_MIN;

   generate
      if (VEC_W % LANE_MAX != 0) begin : g_bad_vec
         $error("simd_lane_bank: VEC_W must be a multiple of the widest lane");
      end
      if (ADDER_STYLE != ADD_BANKED && ADDER_STYLE != ADD_SEGMENTED) begin : g_bad_style
         $error("simd_lane_bank: unknown ADDER_STYLE");
      end

      if (ADDER_STYLE == ADD_BANKED) begin : g_banked
         // One full set of lane adders per element size, chosen afterwards
         wire [VEC_W-1:0] bank [NUM_SIZES];

         for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
            localparam int W  = LANE_MIN << s;
            localparam int NL = VEC_W / W;
            wire [VEC_W-1:0] row;

            for (genvar l = 0; l < NL; l++) begin : g_lane
               simd_lane #(.W(W)) u_lane (
                  .a   (a[l*W +: W]),
                  .b   (b[l*W +: W]),
                  .sub (sub),
                  .y   (row[l*W +: W])
               );
            end

            assign bank[s] = row;
         end

         assign y = bank[sz];
      end else begin : g_segmented
         // One chunked carry chain; the chain restarts at every lane start
         always_comb begin
            int unsigned       msk;
            logic              carry;
            logic              cin;
            logic [LANE_MIN:0] tot;
            msk   = (32'd1 << sz) - 32'd1;
            carry = 1'b0;
            y     = '0;
            for (int c = 0; c < NCHUNK; c++) begin
               cin = ((c & msk) == 0) ? sub : carry;
               tot = {1'b0, a[c*LANE_MIN +: LANE_MIN]}
                   + {1'b0, b[c*LANE_MIN +: LANE_MIN] ^ {LANE_MIN{sub}}}
                   + {{LANE_MIN{1'b0}}, cin};
               y[c*LANE_MIN +: LANE_MIN] = tot[LANE_MIN-1:0];
               carry = tot[LANE_MIN];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
   import simd_addsub_pkg::*;
#(
   parameter int INSN_W      = 32,
   parameter int VEC_W       = 128,
   parameter int LANE_MIN    = 8,
   parameter int PC_W        = 64,
   parameter int ADDER_STYLE = ADD_BANKED
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [INSN_W-1:0]    insn,
   input  logic [PC_W-1:0]      pc_in,
   input  logic [VEC_W-1:0]     vn_data,
   input  logic [VEC_W-1:0]     vm_data,
   output logic [REG_IDX_W-1:0] rn_idx,
   output logic [REG_IDX_W-1:0] rm_idx,
   output logic                 out_valid,
   output logic [VEC_W-1:0]     res_data,
   output logic [REG_IDX_W-1:0] rd_idx,
   output logic                 wr_en,
   output logic                 illegal,
   output logic                 unimpl,
   output logic                 logic_route,
   output logic [PC_W-1:0]      pc_next
);

   localparam int HALF_W = VEC_W / 2;

   generate
      if (INSN_W != 32) begin : g_bad_insn
         $error("simd_addsub_unit: field positions assume a 32-bit word");
      end
      if (VEC_W % 2 != 0) begin : g_bad_half
         $error("simd_addsub_unit: VEC_W must split into two halves");
      end
      if (PC_W < 3) begin : g_bad_pc
         $error("simd_addsub_unit: PC_W too narrow for the step");
      end
   endgenerate

   dec_t             dec;
   logic [VEC_W-1:0] lane_y;
   logic [VEC_W-1:0] masked_y;

   simd_decode #(.INSN_W(INSN_W)) u_dec (
      .insn (insn),
      .dec  (dec)
   );

   simd_lane_bank #(
      .VEC_W       (VEC_W),
      .LANE_MIN    (LANE_MIN),
      .ADDER_STYLE (ADDER_STYLE)
   ) u_bank (
      .a   (vn_data),
      .b   (vm_data),
      .sub (dec.u),
      .sz  (dec.sz),
      .y   (lane_y)
   );

   assign rn_idx   = dec.rn;
   assign rm_idx   = dec.rm;
   assign masked_y = dec.q ? lane_y : {{HALF_W{1'b0}}, lane_y[HALF_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         wr_en       <= 1'b0;
         illegal     <= 1'b0;
         unimpl      <= 1'b0;
         logic_route <= 1'b0;
         res_data    <= '0;
         rd_idx      <= '0;
         pc_next     <= '0;
      end else begin
         out_valid   <= in_valid;
         wr_en       <= in_valid && dec.do_write;
         illegal     <= in_valid && dec.is_illegal;
         unimpl      <= in_valid && dec.is_unimpl;
         logic_route <= in_valid && dec.is_logic;
         if (in_valid) begin
            res_data <= masked_y;
            rd_idx   <= dec.rd;
            pc_next  <= pc_in + PC_W'(PC_STEP);
         end
      end
   end

   // ---------------- assertions ----------------
   AST_LOW_LANE_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && dec.do_write |=> res_data[LANE_MIN-1:0] ==
         ($past(dec.u) ? ($past(vn_data[LANE_MIN-1:0]) - $past(vm_data[LANE_MIN-1:0]))
                       : ($past(vn_data[LANE_MIN-1:0]) + $past(vm_data[LANE_MIN-1:0])))); // R3

   AST_UPPER_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !insn[FLD_Q] |=> res_data[VEC_W-1:HALF_W] == '0); // R4

   AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && insn[FLD_OPC_LO +: OPC_W] == OPC_ARITH && insn[FLD_SZ_LO +: SZ_W] == 2'b11
         && !insn[FLD_Q] |=> illegal && !wr_en); // R5

   AST_LOGIC_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && insn[FLD_OPC_LO +: OPC_W] == OPC_LOGIC |=> logic_route && !wr_en && !illegal); // R6

   AST_UNIMPL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && insn[FLD_OPC_LO +: OPC_W] != OPC_ARITH && insn[FLD_OPC_LO +: OPC_W] != OPC_LOGIC
         |=> unimpl && !wr_en); // R7

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones({wr_en, illegal, unimpl, logic_route}) == 1); // R7

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> pc_next == $past(pc_in) + PC_W'(PC_STEP)); // R8

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !wr_en); // R9

endmodule

// File: tb/tb_simd_addsub_unit.sv
module tb_simd_addsub_unit;

   localparam int CLK_PERIOD = 10;
   localparam int VW = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [31:0]   insn = '0;
   logic [63:0]   pc_in = '0;
   logic [VW-1:0] vn_data = '0;
   logic [VW-1:0] vm_data = '0;

   logic [4:0]    rn_idx, rm_idx, rd_idx, s_rn, s_rm, s_rd;
   logic          out_valid, wr_en, illegal, unimpl, logic_route;
   logic          s_ov, s_wr, s_ill, s_un, s_lr;
   logic [VW-1:0] res_data, s_res;
   logic [63:0]   pc_next, s_pc;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_addsub_unit #(.ADDER_STYLE(0)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .pc_in(pc_in),
      .vn_data(vn_data), .vm_data(vm_data), .rn_idx(rn_idx), .rm_idx(rm_idx),
      .out_valid(out_valid), .res_data(res_data), .rd_idx(rd_idx), .wr_en(wr_en),
      .illegal(illegal), .unimpl(unimpl), .logic_route(logic_route), .pc_next(pc_next)
   );

   simd_addsub_unit #(.ADDER_STYLE(1)) dut_seg (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .pc_in(pc_in),
      .vn_data(vn_data), .vm_data(vm_data), .rn_idx(s_rn), .rm_idx(s_rm),
      .out_valid(s_ov), .res_data(s_res), .rd_idx(s_rd), .wr_en(s_wr),
      .illegal(s_ill), .unimpl(s_un), .logic_route(s_lr), .pc_next(s_pc)
   );

   task automatic check(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic q, input logic u, input logic [1:0] sz,
                                      input logic [4:0] opc, input logic [4:0] rm,
                                      input logic [4:0] rn, input logic [4:0] rd);
      return {1'b0, q, u, 5'b01110, sz, 1'b1, rm, opc, 1'b1, rn, rd};
   endfunction

   // Independent model from R2/R3/R4
   function automatic logic [VW-1:0] ref_op(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                            input logic q, input logic u, input logic [1:0] sz);
      logic [VW-1:0] r;
      r = '0;
      case (sz)
         2'd0: for (int l = 0; l < 16; l++) r[l*8 +: 8]   = u ? a[l*8 +: 8] - b[l*8 +: 8] : a[l*8 +: 8] + b[l*8 +: 8];
         2'd1: for (int l = 0; l < 8; l++)  r[l*16 +: 16] = u ? a[l*16 +: 16] - b[l*16 +: 16] : a[l*16 +: 16] + b[l*16 +: 16];
         2'd2: for (int l = 0; l < 4; l++)  r[l*32 +: 32] = u ? a[l*32 +: 32] - b[l*32 +: 32] : a[l*32 +: 32] + b[l*32 +: 32];
         default: for (int l = 0; l < 2; l++) r[l*64 +: 64] = u ? a[l*64 +: 64] - b[l*64 +: 64] : a[l*64 +: 64] + b[l*64 +: 64];
      endcase
      if (!q) r[127:64] = '0;
      return r;
   endfunction

   // Run one instruction: drive at negedge, sample at the next negedge
   task automatic run_op(input logic [31:0] w, input logic [VW-1:0] a, input logic [VW-1:0] b,
                         input logic [63:0] pc);
      insn = w; vn_data = a; vm_data = b; pc_in = pc; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   typedef struct packed {
      logic          q;
      logic          u;
      logic [1:0]    sz;
      logic [4:0]    opc;
      logic [VW-1:0] a;
      logic [VW-1:0] b;
      logic [VW-1:0] exp;
      logic [3:0]    fl;   // {wr_en, illegal, unimpl, logic_route}
   } vec_t;

   localparam int NV = 15;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 1'b0, 2'd0, 5'b10000, {16{8'hFF}}, {16{8'h01}}, 128'h0, 4'b1000},
      '{1'b1, 1'b1, 2'd0, 5'b10000, 128'h0, {16{8'h01}}, {16{8'hFF}}, 4'b1000},
      '{1'b1, 1'b0, 2'd1, 5'b10000, {8{16'hFFFF}}, {8{16'h0001}}, 128'h0, 4'b1000},
      '{1'b1, 1'b0, 2'd3, 5'b10000, {64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
         {64'h1, 64'h1}, {64'h0000_0001_0000_0000, 64'h0}, 4'b1000},
      '{1'b0, 1'b0, 2'd2, 5'b10000, {64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
         {64'h1, 64'h1}, {64'h0, 64'hFFFF_FFFF_0000_0000}, 4'b1000},
      '{1'b1, 1'b1, 2'd2, 5'b10000, {4{32'h5}}, {4{32'h7}}, {4{32'hFFFF_FFFE}}, 4'b1000},
      '{1'b0, 1'b1, 2'd1, 5'b10000, {8{16'h0100}}, {8{16'h0001}}, {64'h0, {4{16'h00FF}}}, 4'b1000},
      '{1'b1, 1'b1, 2'd3, 5'b10000, 128'h0, {64'h1, 64'h2},
         {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE}, 4'b1000},
      '{1'b0, 1'b0, 2'd3, 5'b10000, {16{8'h11}}, {16{8'h22}}, 128'h0, 4'b0100},
      '{1'b0, 1'b1, 2'd3, 5'b10000, {16{8'h11}}, {16{8'h22}}, 128'h0, 4'b0100},
      '{1'b1, 1'b0, 2'd0, 5'b00011, {16{8'h11}}, {16{8'h22}}, 128'h0, 4'b0001},
      '{1'b0, 1'b0, 2'd3, 5'b00011, {16{8'h11}}, {16{8'h22}}, 128'h0, 4'b0001},
      '{1'b1, 1'b0, 2'd0, 5'b00000, {16{8'h11}}, {16{8'h22}}, 128'h0, 4'b0010},
      '{1'b0, 1'b0, 2'd3, 5'b11111, {16{8'h11}}, {16{8'h22}}, 128'h0, 4'b0010},
      '{1'b0, 1'b0, 2'd0, 5'b10000, {16{8'h80}}, {16{8'h80}}, 128'h0, 4'b1000}
   };

   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;
   function automatic logic [63:0] nxt(input logic [63:0] x);
      logic [63:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 7);
      y = y ^ (y << 17);
      return y;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] w;
      // R10: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10 out_valid", VW'(out_valid), '0);
      check("R10 flags", VW'({wr_en, illegal, unimpl, logic_route}), '0);
      check("R10 res_data", res_data, '0);
      check("R10 pc_next", VW'(pc_next), '0);
      rst_n = 1'b1;

      // R9: idle cycle gives no write
      @(negedge clk);
      check("R9 idle out_valid", VW'(out_valid), '0);
      check("R9 idle wr_en", VW'(wr_en), '0);

      // R1: source indices are combinational
      insn = mk(1'b1, 1'b0, 2'd0, 5'b10000, 5'd22, 5'd13, 5'd7);
      #1;
      check("R1 rn_idx", VW'(rn_idx), VW'(13));
      check("R1 rm_idx", VW'(rm_idx), VW'(22));

      // Table walk: R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         w = mk(TBL[i].q, TBL[i].u, TBL[i].sz, TBL[i].opc, 5'd3, 5'd4, 5'(i + 1));
         run_op(w, TBL[i].a, TBL[i].b, 64'h1000 + 64'(i * 4));
         check("R7 outcome flags", VW'({wr_en, illegal, unimpl, logic_route}), VW'(TBL[i].fl));
         check("R9 out_valid", VW'(out_valid), VW'(1));
         check("R8 pc_next", VW'(pc_next), VW'(64'h1000 + 64'(i * 4) + 64'd4));
         check("R1 rd_idx", VW'(rd_idx), VW'(i + 1));
         if (TBL[i].fl[3]) check("R2 R3 R4 lane result", res_data, TBL[i].exp);
         check("R11 styles agree", s_res ^ res_data, '0);
      end

      // R9: back-to-back instructions, both handled
      @(negedge clk);
      insn = mk(1'b1, 1'b0, 2'd0, 5'b10000, 5'd1, 5'd2, 5'd9);
      vn_data = {16{8'h01}}; vm_data = {16{8'h02}}; pc_in = 64'h40; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R9 first of pair", res_data, {16{8'h03}});
      insn = mk(1'b1, 1'b1, 2'd3, 5'b10000, 5'd1, 5'd2, 5'd10);
      vn_data = {64'd10, 64'd20}; vm_data = {64'd3, 64'd25}; pc_in = 64'hFFFF_FFFF_FFFF_FFFC;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 second of pair", res_data, {64'd7, 64'hFFFF_FFFF_FFFF_FFFB});
      check("R9 second rd", VW'(rd_idx), VW'(10));
      check("R8 pc wrap", VW'(pc_next), '0);
      @(negedge clk);
      check("R9 idle after pair", VW'({out_valid, wr_en}), '0);

      // Pseudo-random arithmetic against the model, both styles
      for (int k = 0; k < 300; k++) begin
         logic [VW-1:0] a, b, e;
         logic q, u;
         logic [1:0] sz;
         rng = nxt(rng); a[63:0] = rng;
         rng = nxt(rng); a[127:64] = rng;
         rng = nxt(rng); b[63:0] = rng;
         rng = nxt(rng); b[127:64] = rng;
         rng = nxt(rng);
         q = rng[0]; u = rng[1]; sz = rng[3:2];
         if (sz == 2'd3) q = 1'b1;
         e = ref_op(a, b, q, u, sz);
         run_op(mk(q, u, sz, 5'b10000, rng[8:4], rng[13:9], rng[18:14]), a, b, rng);
         check("R3 random lanes", res_data, e);
         check("R11 random styles agree", s_res, e);
         check("R11 random flags agree", VW'({s_wr, s_ill, s_un, s_lr}), VW'(4'b1000));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule